// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives the oversampling tick for a serial transmitter and receiver from a fast reference clock. Software programs a divisor with a 16-bit whole part and a fractional part counted in sixteenths. The tick then arrives on average once every (whole + fraction/16) reference cycles. Each tick period is either the whole part or one cycle longer. The longer periods are spread over every run of sixteen ticks so that the average is exact and the jitter stays within one reference cycle.

A third register holds the fraction and an oversampling ratio of 16, 8 or 4. The block counts ticks against that ratio and raises a bit strobe on the tick that closes each bit time. The value to program is the reference frequency divided by (bit rate × ratio), rounded to the nearest sixteenth. For example, 24 MHz at 9600 bps with 16x oversampling needs 156.25, which is whole part 0x009C with fraction 4. 2400 bps from the same clock needs exactly 625, which is high byte 0x02 and low byte 0x71. At 115200 bps the exact value is about 13.02, so it rounds to 13 with fraction 0.

Registers are written through one byte-wide data bus with one write strobe per register. There is no data stream, so every pin is a plain control or status signal with no handshake. Any register write restarts the period counter, the fraction accumulator and the ratio counter.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset all three registers are zero, and `tick` and `bit_tick` stay low until the divisor is programmed.
- R2: With whole part I ≥ 2 and fraction 0, `tick` is a one-cycle pulse repeating every I reference cycles.
- R3: With fraction F, every run of 16 consecutive tick periods after a restart holds exactly F periods of length I+1, and the rest have length I.
- R4: Period k after a restart (k = 0, 1, 2 …) has length I+1 exactly when floor((k+1)·F/16) > floor(k·F/16); otherwise it has length I. Period 0 is therefore never lengthened.
- R5: A whole part of 0 stops all ticks and bit strobes, whatever the fraction.
- R6: Whole part 1 with fraction 0 gives `tick` high on every cycle.
- R7: A write to any register clears `tick` and `bit_tick` on the next cycle and restarts timing. The first tick comes exactly I cycles after the clock edge that takes the write.
- R8: Register fields are as follows. The high-byte write sets divisor bits [15:8]. The low-byte write sets bits [7:0]. The config write takes the fraction from data bits [3:0] and the ratio from bits [5:4]: 00 means 16x, 01 means 8x, and 10 or 11 mean 4x. Config bits [7:6] have no effect.
- R9: `bit_tick` rises together with the N-th, 2N-th, … tick after a restart, where N is the selected ratio. It is never high without `tick`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_hi | input | 1 | Write strobe for the divisor high byte |
| wr_lo | input | 1 | Write strobe for the divisor low byte |
| wr_cfg | input | 1 | Write strobe for the fraction and ratio register |
| wr_data | input | 8 | Write data shared by the three strobes |
| tick | output | 1 | One-cycle oversampling tick |
| bit_tick | output | 1 | One-cycle strobe at the end of each bit time |

## Verification
The bench predicts every tick time from the floor formula of R4. It then runs the generator with several divisors. A large exact divisor (625) checks integer counting and the 16x bit strobe. Quarter, eleven-sixteenths, fifteen-sixteenths and one-half fractions check that lengthened periods are placed per period rather than bunched. The fifteen-sixteenths case pushes accumulator carries into nearly every period. Whole part 1, with and without a fraction, covers back-to-back ticks. A zero whole part shows ticks stopping, and a low-byte write in mid-period shows that timing restarts from the write rather than running on.

// File: rtl/baud_pkg.sv
package baud_pkg;

  typedef enum logic [1:0] {
    OS_16X  = 2'b00,
    OS_8X   = 2'b01,
    OS_4X_A = 2'b10,
    OS_4X_B = 2'b11
  } os_mode_e;

  localparam int OS_MAX   = 16;
  localparam int OS_CNT_W = $clog2(OS_MAX);

  function automatic logic [OS_CNT_W:0] os_ratio(input os_mode_e m);
    case (m)
      OS_16X:  return (OS_CNT_W+1)'(16);
      OS_8X:   return (OS_CNT_W+1)'(8);
      default: return (OS_CNT_W+1)'(4);
    endcase
  endfunction

endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import baud_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int FRAC_W   = 4,
  parameter int MODE_LSB = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_hi,
  input  logic                  wr_lo,
  input  logic                  wr_cfg,
  input  logic [BYTE_W-1:0]     wr_data,
  output logic [2*BYTE_W-1:0]   int_div,
  output logic [FRAC_W-1:0]     frac,
  output os_mode_e              mode,
  output logic                  restart
);

  logic [BYTE_W-1:0] hi_q, lo_q;

  assign int_div = {hi_q, lo_q};
  assign restart = wr_hi | wr_lo | wr_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
      frac <= '0;
      mode <= OS_16X;
    end else begin
      if (wr_hi) hi_q <= wr_data;
      if (wr_lo) lo_q <= wr_data;
      if (wr_cfg) begin
        frac <= wr_data[FRAC_W-1:0];
        mode <= os_mode_e'(wr_data[MODE_LSB+1:MODE_LSB]);
      end
    end
  end

endmodule

// File: rtl/frac_accum.sv
module frac_accum #(
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              advance,
  input  logic [FRAC_W-1:0] frac,
  output logic              stretch
);

  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  // The carry out of acc + frac marks the period that absorbs one extra cycle
  assign sum     = {1'b0, acc_q} + {1'b0, frac};
  assign stretch = sum[FRAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (restart) acc_q <= '0;
    else if (advance) acc_q <= sum[FRAC_W-1:0];
  end

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] int_div,
  input  logic             stretch,
  output logic             hit,
  output logic             tick_q,
  output logic [CNT_W-1:0] cnt
);

  logic             enable;
  logic [CNT_W:0]   last_val;

  assign enable   = (int_div != '0);
  assign last_val = {1'b0, int_div} + {{CNT_W{1'b0}}, stretch} - (CNT_W+1)'(1);
  assign hit      = enable && ({1'b0, cnt} == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      tick_q <= 1'b0;
    end else if (restart) begin
      cnt    <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= hit;
      if (hit)         cnt <= '0;
      else if (enable) cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/os_divider.sv
module os_divider
  import baud_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     restart,
  input  logic     advance,
  input  os_mode_e mode,
  output logic     bit_q
);

  logic [OS_CNT_W-1:0] os_cnt;
  logic [OS_CNT_W:0]   ratio;
  logic                last;

  assign ratio = os_ratio(mode);
  assign last  = ({1'b0, os_cnt} == ratio - (OS_CNT_W+1)'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_cnt <= '0;
      bit_q  <= 1'b0;
    end else if (restart) begin
      os_cnt <= '0;
      bit_q  <= 1'b0;
    end else begin
      bit_q <= advance && last;
      if (advance) os_cnt <= last ? '0 : os_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import baud_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic              wr_cfg,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              tick,
  output logic              bit_tick
);

  localparam int INT_W = 2 * BYTE_W;

  logic [INT_W-1:0]  int_div;
  logic [FRAC_W-1:0] frac;
  os_mode_e          mode;
  logic              wr_any;
  logic              stretch;
  logic              hit;
  logic [INT_W-1:0]  cnt;

  baud_regs #(.BYTE_W(BYTE_W), .FRAC_W(FRAC_W), .MODE_LSB(4)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_cfg(wr_cfg),
    .wr_data(wr_data), .int_div(int_div), .frac(frac), .mode(mode),
    .restart(wr_any)
  );

  frac_accum #(.FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .restart(wr_any), .advance(hit),
    .frac(frac), .stretch(stretch)
  );

  tick_counter #(.CNT_W(INT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(wr_any), .int_div(int_div),
    .stretch(stretch), .hit(hit), .tick_q(tick), .cnt(cnt)
  );

  os_divider u_os (
    .clk(clk), .rst_n(rst_n), .restart(wr_any), .advance(hit),
    .mode(mode), .bit_q(bit_tick)
  );

endmodule

// File: rtl/baud_checker.sv
module baud_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             restart,
  input logic [CNT_W-1:0] int_div,
  input logic [CNT_W-1:0] cnt,
  input logic             tick,
  input logic             bit_tick
);

  p_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && int_div > CNT_W'(1)) |=> !tick)
    else $error("R2: tick lasted more than one cycle");

  p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int_div != '0) |-> (cnt <= int_div))
    else $error("R3: period counter beyond divisor");

  p_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int_div == '0) |-> (!tick && !bit_tick))
    else $error("R5: tick while divisor is zero");

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!tick && !bit_tick))
    else $error("R7: output not cleared by register write");

  p_bit_in_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> tick)
    else $error("R9: bit strobe without tick");

endmodule

bind frac_baud_gen baud_checker #(.CNT_W(INT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(wr_any), .int_div(int_div),
  .cnt(cnt), .tick(tick), .bit_tick(bit_tick)
);

// File: tb/tb_frac_baud_gen.sv
`timescale 1ns/1ps
module tb_frac_baud_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_hi = 1'b0, wr_lo = 1'b0, wr_cfg = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tick, bit_tick;

  frac_baud_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_cfg(wr_cfg),
    .wr_data(wr_data), .tick(tick), .bit_tick(bit_tick)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    checks = 0, errors = 0;
  int    exp_time[$];
  bit    exp_bit[$];
  bit    armed = 1'b0, run_done = 1'b0, finished = 1'b0;
  int    seen = 0;
  string cur_tag = "R1";
  logic [7:0] sh_hi = 8'h00, sh_lo = 8'h00, sh_cfg = 8'h00;
  int    mt;
  bit    mb;

  // Monitor: pops the expected tick schedule and compares
  always @(negedge clk) begin
    if (armed) begin
      if (exp_time.size() > 0 && exp_time[0] < cyc) begin
        checks++; errors++;
        $display("FAIL %s: tick missing at cycle %0d (actual none, expected tick)", cur_tag, exp_time[0]);
        void'(exp_time.pop_front()); void'(exp_bit.pop_front());
        if (exp_time.size() == 0) begin armed = 1'b0; run_done = 1'b1; end
      end else if (tick) begin
        seen++; checks++;
        if (exp_time.size() == 0) begin
          errors++;
          $display("FAIL %s: unexpected tick at cycle %0d (actual 1, expected 0)", cur_tag, cyc);
        end else begin
          mt = exp_time.pop_front();
          mb = exp_bit.pop_front();
          if (mt != cyc) begin
            errors++;
            $display("FAIL %s: tick at cycle %0d, expected cycle %0d", cur_tag, cyc, mt);
          end else if (mb != bit_tick) begin
            errors++;
            $display("FAIL R9 (%s): bit_tick at cycle %0d actual %0b expected %0b", cur_tag, cyc, bit_tick, mb);
          end
          if (exp_time.size() == 0) begin armed = 1'b0; run_done = 1'b1; end
        end
      end else if (bit_tick) begin
        checks++; errors++;
        $display("FAIL R9: bit_tick without tick at cycle %0d (actual 1, expected 0)", cyc);
      end
    end
  end

  task automatic wr(input int sel, input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    case (sel)
      0: begin wr_hi = 1'b1;  sh_hi = d;  end
      1: begin wr_lo = 1'b1;  sh_lo = d;  end
      default: begin wr_cfg = 1'b1; sh_cfg = d; end
    endcase
    @(negedge clk);
    wr_hi = 1'b0; wr_lo = 1'b0; wr_cfg = 1'b0;
  endtask

  task automatic program_div(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] cfg);
    armed = 1'b0;
    exp_time.delete(); exp_bit.delete();
    wr(2, cfg);
    wr(0, hi);
    wr(1, lo);
  endtask

  // Driver: expected schedule from the R4 floor rule; must be called at the
  // negedge right after the last write edge
  task automatic expect_run(input string tag, input int n);
    int i_div, f, ratio, t, len;
    i_div = {sh_hi, sh_lo};
    f     = sh_cfg[3:0];
    ratio = sh_cfg[5] ? 4 : (sh_cfg[4] ? 8 : 16);
    t     = cyc;
    for (int k = 0; k < n; k++) begin
      len = i_div + (((k + 1) * f) / 16 - (k * f) / 16);
      t += len;
      exp_time.push_back(t);
      exp_bit.push_back(((k + 1) % ratio) == 0);
    end
    cur_tag  = tag;
    seen     = 0;
    run_done = 1'b0;
    armed    = 1'b1;
    while (!run_done) @(posedge clk);
    checks++;
    if (seen != n) begin
      errors++;
      $display("FAIL %s: saw %0d ticks, expected %0d", tag, seen, n);
    end
  endtask

  task automatic expect_none(input string tag, input int ncyc);
    cur_tag = tag;
    seen    = 0;
    armed   = 1'b1;
    repeat (ncyc) @(negedge clk);
    armed   = 1'b0;
    checks++;
    if (seen != 0) begin
      errors++;
      $display("FAIL %s: saw %0d ticks, expected 0", tag, seen);
    end
  endtask

  initial begin : watchdog
    while (cyc < 150000 && !finished) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int quiet;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: nothing ticks out of reset
    quiet = 0;
    repeat (60) begin
      @(negedge clk);
      if (tick || bit_tick) quiet++;
    end
    checks++;
    if (quiet != 0) begin
      errors++;
      $display("FAIL R1: %0d active cycles after reset, expected 0", quiet);
    end

    program_div(8'h02, 8'h71, 8'h00);  expect_run("R8_R2_625", 18);
    program_div(8'h00, 8'h9C, 8'h04);  expect_run("R3_R4_156q", 34);
    program_div(8'h00, 8'h03, 8'h1B);  expect_run("R3_R4_8x", 40);
    program_div(8'h00, 8'h02, 8'h2F);  expect_run("R4_R9_4x", 36);
    program_div(8'h00, 8'h01, 8'h00);  expect_run("R6", 40);
    program_div(8'h00, 8'h01, 8'h08);  expect_run("R3_half", 32);
    program_div(8'h00, 8'h05, 8'hF3);  expect_run("R8_mode11", 24);
    program_div(8'h00, 8'h00, 8'h05);  expect_none("R5", 300);

    // R7: restart in mid-period with a low-byte write only
    program_div(8'h00, 8'h0A, 8'h00);  expect_run("R7_pre", 3);
    repeat (4) @(negedge clk);
    wr(1, 8'h07);
    expect_run("R7", 20);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule